// File: doc/BRIEF.md
# Receive Pattern Synchronizer and Checker

This block sits on the receive side of a bit error rate tester. Each receive clock it takes one serial bit and predicts what that bit should be from the bits that came before it. It uses the same pattern configuration as the transmit generator: the pseudorandom or repetitive mode, the pattern length and the second feedback tap. For a pseudorandom pattern the checker synchronizes by itself, because the prediction comes only from bits already received. It needs no copy of the transmitter state.

While searching, the block counts consecutive correct predictions and declares lock once the count reaches 34 plus the pattern length. While locked, every wrong prediction raises a one-cycle error strobe, which an external counter accumulates. A burst of errors drops the lock. The search then either restarts by itself or waits for a manual restart, depending on a control input. Two level indicators report a stream that is stuck at all ones or all zeros, so that software can tell a real lock apart from a dead line. A snapshot of the last 32 processed bits can be taken on demand. A loopback select feeds the locally transmitted bit in place of the line input, and an inversion control complements the incoming stream before it is checked.

Top module: `prbs_rx_checker`

## Requirements
- R1: In pseudorandom mode (mode input 1) the predicted bit is the XOR of the processed bit received `pat_len_i+1` cycles earlier and the one received `tap_sel_i+1` cycles earlier. `pat_len_i` holds n-1 for a polynomial of degree n, and `tap_sel_i` holds m-1 for its inner term m. An all-zeros stream also satisfies this prediction.
- R2: In repetitive mode (mode input 0) the predicted bit is the processed bit received `pat_len_i+1` cycles earlier, so any stream that repeats with period `pat_len_i+1` is accepted.
- R3: While searching, the block counts consecutive correct predictions and clears the count on any wrong one. `sync_o` rises at the clock edge that samples the (34 + `pat_len_i` + 1)-th consecutive correct bit.
- R4: `bit_err_o` is registered. It is high for exactly the cycle after a bit sampled while locked was mispredicted, and it is never high after a bit sampled while not locked.
- R5: While locked, the block drops `sync_o` at the edge that samples the error bringing the count of errors among the last 64 locked bits to 6. That error still produces its strobe.
- R6: After a loss of lock, `auto_off_i` = 0 restarts the search at once. `auto_off_i` = 1 keeps `sync_o` low, whatever the stream does, until a manual restart.
- R7: A rising edge of `resync_i` restarts the search and clears the error history: `sync_o` is low after that edge and no error strobe follows it, even when the same bit was mispredicted. Holding `resync_i` high has no further effect.
- R8: With `loop_en_i` = 1 the checker processes `tx_data_i` and ignores `rx_data_i`.
- R9: With `rx_inv_i` = 1 the selected bit is complemented before prediction, history and capture.
- R10: `all_ones_o` (`all_zeros_o`) is high when the last 32 processed bits are all 1 (all 0). Both flags stay low until 32 bits have been processed since reset.
- R11: A rising edge of `cap_reg_i | cap_pin_i` loads `cap_data_o` with the last 32 processed bits, counting the bit sampled at that edge, with bit 0 the newest. A rise on one control while the other is already high loads nothing.
- R12: After reset `sync_o`, `bit_err_o`, both flags and `cap_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data_i | input | 1 | Serial line data |
| tx_data_i | input | 1 | Locally transmitted bit, used in loopback |
| loop_en_i | input | 1 | 1 = check `tx_data_i` instead of the line |
| rx_inv_i | input | 1 | 1 = complement the selected bit |
| prbs_sel_i | input | 1 | 1 = pseudorandom, 0 = repetitive |
| pat_len_i | input | 5 | Pattern length minus one |
| tap_sel_i | input | 5 | Inner feedback term minus one |
| auto_off_i | input | 1 | 1 = no automatic search after loss of lock |
| resync_i | input | 1 | Rising edge restarts the search |
| cap_reg_i | input | 1 | Capture control from register |
| cap_pin_i | input | 1 | Capture control from pin |
| sync_o | output | 1 | Locked flag |
| all_ones_o | output | 1 | Last 32 bits all ones |
| all_zeros_o | output | 1 | Last 32 bits all zeros |
| bit_err_o | output | 1 | One-cycle mispredicted-bit strobe |
| cap_data_o | output | 32 | Captured bits, bit 0 newest |

## Verification
A manual restart can arrive on the same edge as a mispredicted bit while the block is locked. The restart must win: the error strobe is suppressed and the lock drops together. The bench provokes this by raising `resync_i` in the same cycle as it flips one line bit of a locked pseudorandom stream. It expects `bit_err_o` and `sync_o` to be low one cycle later, and the behavioural model, compared on every clock, confirms that the error history is empty on relock.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int unsigned CHK_HIST_W    = 32;
  localparam int unsigned CHK_SYNC_BASE = 34;
  localparam int unsigned CHK_WIN       = 64;
  localparam int unsigned CHK_ERR_LIMIT = 6;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_LOCK   = 2'd1,
    ST_HOLD   = 2'd2
  } chk_state_e;

endpackage

// File: rtl/rxc_front.sv
module rxc_front #(
  parameter int unsigned HIST_W = prbs_chk_pkg::CHK_HIST_W,
  parameter int unsigned LEN_W  = $clog2(HIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_data_i,
  input  logic              tx_data_i,
  input  logic              loop_en_i,
  input  logic              rx_inv_i,
  input  logic              prbs_sel_i,
  input  logic [LEN_W-1:0]  pat_len_i,
  input  logic [LEN_W-1:0]  tap_sel_i,
  output logic              cur_bit_o,
  output logic              pred_bit_o,
  output logic [HIST_W-1:0] hist_next_o,
  output logic              all_ones_o,
  output logic              all_zeros_o
);

  localparam int unsigned FILL_W = $clog2(HIST_W + 1);

  logic [HIST_W-1:0] hist_q;
  logic [FILL_W-1:0] fill_q;
  logic              hist_full;

  // Prediction from past processed bits; index 0 is the previous bit.
  function automatic logic f_predict(input logic [HIST_W-1:0] h,
                                     input logic [LEN_W-1:0]  tap_a,
                                     input logic [LEN_W-1:0]  tap_b,
                                     input logic              prbs);
    logic a_bit;
    a_bit = h[tap_a];
    return prbs ? (a_bit ^ h[tap_b]) : a_bit;
  endfunction

  assign cur_bit_o   = (loop_en_i ? tx_data_i : rx_data_i) ^ rx_inv_i;
  assign pred_bit_o  = f_predict(hist_q, pat_len_i, tap_sel_i, prbs_sel_i);
  assign hist_next_o = {hist_q[HIST_W-2:0], cur_bit_o};
  assign hist_full   = (fill_q == FILL_W'(HIST_W));
  assign all_ones_o  = hist_full & (&hist_q);
  assign all_zeros_o = hist_full & ~(|hist_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else begin
      hist_q <= hist_next_o;
      if (!hist_full) fill_q <= fill_q + FILL_W'(1);
    end
  end

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(all_ones_o && all_zeros_o));

  assert_fill_monotone_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hist_full |=> hist_full);

endmodule

// File: rtl/rxc_capture.sv
module rxc_capture #(
  parameter int unsigned HIST_W = prbs_chk_pkg::CHK_HIST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_a_i,
  input  logic              trig_b_i,
  input  logic [HIST_W-1:0] snap_i,
  output logic [HIST_W-1:0] cap_o
);

  logic trig_now;
  logic trig_q;
  logic cap_rise;

  assign trig_now = trig_a_i | trig_b_i;
  assign cap_rise = trig_now & ~trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      cap_o  <= '0;
    end else begin
      trig_q <= trig_now;
      if (cap_rise) cap_o <= snap_i;
    end
  end

  assert_cap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> $stable(cap_o));

  assert_cap_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> !cap_rise);

endmodule

// File: rtl/rxc_lock.sv
module rxc_lock
  import prbs_chk_pkg::*;
#(
  parameter int unsigned HIST_W    = CHK_HIST_W,
  parameter int unsigned LEN_W     = $clog2(HIST_W),
  parameter int unsigned SYNC_BASE = CHK_SYNC_BASE,
  parameter int unsigned WIN       = CHK_WIN,
  parameter int unsigned ERR_LIMIT = CHK_ERR_LIMIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_bit_i,
  input  logic             pred_bit_i,
  input  logic [LEN_W-1:0] pat_len_i,
  input  logic             auto_off_i,
  input  logic             resync_i,
  output logic             sync_o,
  output logic             bit_err_o
);

  localparam int unsigned RUN_W = $clog2(SYNC_BASE + HIST_W + 1);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  chk_state_e       st_q;
  logic [RUN_W-1:0] run_q;
  logic [WIN-1:0]   win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             resync_q;
  logic             err_q;

  logic             mis;
  logic             resync_rise;
  logic [RUN_W-1:0] run_need;
  logic [RUN_W-1:0] run_inc;
  logic [CNT_W-1:0] cnt_sum;
  logic             lock_evt;
  logic             loss_evt;

  // Clean bits needed before lock: base plus pattern length.
  function automatic logic [RUN_W-1:0] f_need(input logic [LEN_W-1:0] len_m1);
    return RUN_W'(SYNC_BASE + 1) + RUN_W'(len_m1);
  endfunction

  // Sliding-window error count: add newest, drop the one leaving.
  function automatic logic [CNT_W-1:0] f_slide(input logic [CNT_W-1:0] c,
                                               input logic add,
                                               input logic drop);
    return c + CNT_W'(add) - CNT_W'(drop);
  endfunction

  assign mis         = cur_bit_i ^ pred_bit_i;
  assign resync_rise = resync_i & ~resync_q;
  assign run_need    = f_need(pat_len_i);
  assign run_inc     = run_q + RUN_W'(1);
  assign cnt_sum     = f_slide(cnt_q, mis, win_q[WIN-1]);
  assign lock_evt    = (st_q == ST_SEARCH) && !resync_rise && !mis && (run_inc >= run_need);
  assign loss_evt    = (st_q == ST_LOCK) && !resync_rise && (cnt_sum >= CNT_W'(ERR_LIMIT));
  assign sync_o      = (st_q == ST_LOCK);
  assign bit_err_o   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_SEARCH;
      run_q    <= '0;
      win_q    <= '0;
      cnt_q    <= '0;
      resync_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      resync_q <= resync_i;
      err_q    <= 1'b0;
      if (resync_rise) begin
        st_q  <= ST_SEARCH;
        run_q <= '0;
        win_q <= '0;
        cnt_q <= '0;
      end else begin
        case (st_q)
          ST_SEARCH: begin
            if (mis) begin
              run_q <= '0;
            end else if (lock_evt) begin
              st_q  <= ST_LOCK;
              run_q <= '0;
              win_q <= '0;
              cnt_q <= '0;
            end else begin
              run_q <= run_inc;
            end
          end
          ST_LOCK: begin
            err_q <= mis;
            if (loss_evt) begin
              st_q  <= auto_off_i ? ST_HOLD : ST_SEARCH;
              run_q <= '0;
              win_q <= '0;
              cnt_q <= '0;
            end else begin
              win_q <= {win_q[WIN-2:0], mis};
              cnt_q <= cnt_sum;
            end
          end
          ST_HOLD: begin
            run_q <= '0;
          end
          default: st_q <= ST_SEARCH;
        endcase
      end
    end
  end

  assert_err_only_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_LOCK) |=> !bit_err_o);

  assert_err_on_mis_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_LOCK) && mis && !resync_rise) |=> bit_err_o);

  assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |-> (cnt_q < CNT_W'(ERR_LIMIT)));

  assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_HOLD) && !resync_rise) |=> (st_q == ST_HOLD));

  assert_search_no_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH) |=> (st_q != ST_HOLD));

  assert_resync_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_rise |=> ((st_q == ST_SEARCH) && !bit_err_o));

  assert_lock_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> !bit_err_o);

endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker
  import prbs_chk_pkg::*;
#(
  parameter int unsigned HIST_W    = CHK_HIST_W,
  parameter int unsigned LEN_W     = $clog2(HIST_W),
  parameter int unsigned SYNC_BASE = CHK_SYNC_BASE,
  parameter int unsigned WIN       = CHK_WIN,
  parameter int unsigned ERR_LIMIT = CHK_ERR_LIMIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_data_i,
  input  logic              tx_data_i,
  input  logic              loop_en_i,
  input  logic              rx_inv_i,
  input  logic              prbs_sel_i,
  input  logic [LEN_W-1:0]  pat_len_i,
  input  logic [LEN_W-1:0]  tap_sel_i,
  input  logic              auto_off_i,
  input  logic              resync_i,
  input  logic              cap_reg_i,
  input  logic              cap_pin_i,
  output logic              sync_o,
  output logic              all_ones_o,
  output logic              all_zeros_o,
  output logic              bit_err_o,
  output logic [HIST_W-1:0] cap_data_o
);

  logic              cur_bit;
  logic              pred_bit;
  logic [HIST_W-1:0] hist_next;

  rxc_front #(.HIST_W(HIST_W), .LEN_W(LEN_W)) u_front (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data_i   (rx_data_i),
    .tx_data_i   (tx_data_i),
    .loop_en_i   (loop_en_i),
    .rx_inv_i    (rx_inv_i),
    .prbs_sel_i  (prbs_sel_i),
    .pat_len_i   (pat_len_i),
    .tap_sel_i   (tap_sel_i),
    .cur_bit_o   (cur_bit),
    .pred_bit_o  (pred_bit),
    .hist_next_o (hist_next),
    .all_ones_o  (all_ones_o),
    .all_zeros_o (all_zeros_o)
  );

  rxc_lock #(
    .HIST_W(HIST_W), .LEN_W(LEN_W), .SYNC_BASE(SYNC_BASE),
    .WIN(WIN), .ERR_LIMIT(ERR_LIMIT)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_bit_i  (cur_bit),
    .pred_bit_i (pred_bit),
    .pat_len_i  (pat_len_i),
    .auto_off_i (auto_off_i),
    .resync_i   (resync_i),
    .sync_o     (sync_o),
    .bit_err_o  (bit_err_o)
  );

  rxc_capture #(.HIST_W(HIST_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_a_i (cap_reg_i),
    .trig_b_i (cap_pin_i),
    .snap_i   (hist_next),
    .cap_o    (cap_data_o)
  );

endmodule

// File: tb/test_prbs_rx_checker.sv
module test_prbs_rx_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_data_i = 1'b0, tx_data_i = 1'b0, loop_en_i = 1'b0, rx_inv_i = 1'b0;
  logic        prbs_sel_i = 1'b1;
  logic [4:0]  pat_len_i = 5'd6, tap_sel_i = 5'd5;
  logic        auto_off_i = 1'b0, resync_i = 1'b0, cap_reg_i = 1'b0, cap_pin_i = 1'b0;
  logic        sync_o, all_ones_o, all_zeros_o, bit_err_o;
  logic [31:0] cap_data_o;

  always #2 clk = ~clk;

  prbs_rx_checker i_prbs_rx_checker (
    .clk(clk), .rst_n(rst_n), .rx_data_i(rx_data_i), .tx_data_i(tx_data_i),
    .loop_en_i(loop_en_i), .rx_inv_i(rx_inv_i), .prbs_sel_i(prbs_sel_i),
    .pat_len_i(pat_len_i), .tap_sel_i(tap_sel_i), .auto_off_i(auto_off_i),
    .resync_i(resync_i), .cap_reg_i(cap_reg_i), .cap_pin_i(cap_pin_i),
    .sync_o(sync_o), .all_ones_o(all_ones_o), .all_zeros_o(all_zeros_o),
    .bit_err_o(bit_err_o), .cap_data_o(cap_data_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Behavioural reference state
  int          m_hist[32];
  int          m_fill = 0;
  int          m_state = 0;   // 0 search, 1 locked, 2 hold
  int          m_run = 0;
  bit          m_win[$];
  bit          m_rs_prev = 0, m_cap_prev = 0, m_err = 0;
  logic [31:0] m_cap = '0;

  // Stimulus sources
  logic [6:0]  lfsr = 7'h5A;
  int          src = 0;       // 0 copy tx, 1 random, 2 ones, 3 zeros, 4 repeat, 5 inverted tx
  int          rep_idx = 0;
  bit          flip_pending = 0;
  logic [4:0]  rep_pat = 5'b10110;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_all(int v);
    if (m_fill < 32) return 0;
    for (int i = 0; i < 32; i++) if (m_hist[i] != v) return 0;
    return 1;
  endfunction

  task automatic model_step();
    int d, pred, sum;
    bit mis, rs_rise, trig;
    d    = (loop_en_i ? tx_data_i : rx_data_i) ^ rx_inv_i;
    pred = prbs_sel_i ? (m_hist[pat_len_i] ^ m_hist[tap_sel_i]) : m_hist[pat_len_i];
    mis  = (d != pred);
    rs_rise = resync_i && !m_rs_prev;
    m_rs_prev = resync_i;
    m_err = 0;
    if (rs_rise) begin
      m_state = 0; m_run = 0; m_win.delete();
    end else if (m_state == 0) begin
      if (mis) m_run = 0;
      else begin
        m_run++;
        if (m_run >= 34 + pat_len_i + 1) begin
          m_state = 1; m_run = 0; m_win.delete();
        end
      end
    end else if (m_state == 1) begin
      m_err = mis;
      m_win.push_front(mis);
      if (m_win.size() > 64) void'(m_win.pop_back());
      sum = 0;
      foreach (m_win[i]) sum += m_win[i];
      if (sum >= 6) begin
        m_state = auto_off_i ? 2 : 0; m_run = 0; m_win.delete();
      end
    end
    for (int k = 31; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = d;
    if (m_fill < 32) m_fill++;
    trig = cap_reg_i | cap_pin_i;
    if (trig && !m_cap_prev) for (int i = 0; i < 32; i++) m_cap[i] = m_hist[i][0];
    m_cap_prev = trig;
  endtask

  task automatic compare_all();
    chk("R3 sync_o", {31'd0, sync_o}, {31'd0, m_state == 1});
    chk("R4 bit_err_o", {31'd0, bit_err_o}, {31'd0, m_err});
    chk("R10 all_ones_o", {31'd0, all_ones_o}, {31'd0, m_all(1)});
    chk("R10 all_zeros_o", {31'd0, all_zeros_o}, {31'd0, m_all(0)});
    chk("R11 cap_data_o", cap_data_o, m_cap);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare_all();
  endtask

  task automatic bits(int n);
    for (int i = 0; i < n; i++) begin
      logic nb;
      nb = lfsr[6] ^ lfsr[5];
      lfsr = {lfsr[5:0], nb};
      tx_data_i = nb;
      case (src)
        1: rx_data_i = 1'($urandom % 2);
        2: rx_data_i = 1'b1;
        3: rx_data_i = 1'b0;
        4: begin rx_data_i = rep_pat[rep_idx]; rep_idx = (rep_idx + 1) % 5; end
        5: rx_data_i = ~nb;
        default: rx_data_i = nb;
      endcase
      if (flip_pending) begin rx_data_i = ~rx_data_i; flip_pending = 0; end
      tick();
    end
  endtask

  task automatic resync_pulse();
    resync_i = 1'b1; bits(1); resync_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int ec;
    logic [31:0] saved;
    foreach (m_hist[i]) m_hist[i] = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 sync_o", {31'd0, sync_o}, 32'd0);
    chk("R12 bit_err_o", {31'd0, bit_err_o}, 32'd0);
    chk("R12 flags", {30'd0, all_ones_o, all_zeros_o}, 32'd0);
    chk("R12 cap_data_o", cap_data_o, 32'd0);
    rst_n = 1'b1;

    // R1/R3: clean pseudorandom stream, degree 7, inner term 6
    bits(60);
    chk("R1 lock on prbs", {31'd0, sync_o}, 32'd1);

    // R4: one line error gives three mispredictions with two taps
    flip_pending = 1; ec = 0;
    for (int i = 0; i < 20; i++) begin bits(1); ec += bit_err_o; end
    chk("R4 error strobes per flip", ec, 32'd3);
    chk("R4 lock kept", {31'd0, sync_o}, 32'd1);
    bits(80);

    // R5: two flips give six errors, lock lost; R6 auto search relocks
    flip_pending = 1; bits(10); flip_pending = 1; bits(20);
    chk("R5 lock lost", {31'd0, sync_o}, 32'd0);
    bits(80);
    chk("R6 auto relock", {31'd0, sync_o}, 32'd1);

    // R6: automatic search disabled stays out of lock
    auto_off_i = 1'b1;
    flip_pending = 1; bits(10); flip_pending = 1; bits(100);
    chk("R6 held out of lock", {31'd0, sync_o}, 32'd0);
    // R7: manual restart
    resync_pulse(); bits(60);
    chk("R7 relock after restart", {31'd0, sync_o}, 32'd1);
    resync_i = 1'b1; bits(1);
    chk("R7 restart drops lock", {31'd0, sync_o}, 32'd0);
    bits(60);
    chk("R7 held high no effect", {31'd0, sync_o}, 32'd1);
    resync_i = 1'b0; bits(2);
    // R7: restart and misprediction on the same edge
    resync_i = 1'b1; flip_pending = 1; bits(1);
    chk("R7 restart beats error", {30'd0, bit_err_o, sync_o}, 32'd0);
    resync_i = 1'b0; bits(60);
    auto_off_i = 1'b0;

    // R9: inverted line
    src = 5; resync_pulse(); bits(100);
    chk("R9 no lock without inversion", {31'd0, sync_o}, 32'd0);
    rx_inv_i = 1'b1; bits(60);
    chk("R9 lock with inversion", {31'd0, sync_o}, 32'd1);
    rx_inv_i = 1'b0;

    // R8: loopback ignores line garbage
    src = 1; loop_en_i = 1'b1; resync_pulse(); bits(60);
    chk("R8 lock in loopback", {31'd0, sync_o}, 32'd1);
    ec = 0;
    for (int i = 0; i < 50; i++) begin bits(1); ec += bit_err_o; end
    chk("R8 line ignored", ec, 32'd0);
    loop_en_i = 1'b0;

    // R2: repetitive pattern of length 5
    prbs_sel_i = 1'b0; pat_len_i = 5'd4; src = 4; resync_pulse(); bits(60);
    chk("R2 repetitive lock", {31'd0, sync_o}, 32'd1);

    // R11: capture on pin rise, periodic content
    cap_pin_i = 1'b1; bits(1); cap_pin_i = 1'b0;
    chk("R11 capture periodic", {5'd0, cap_data_o[26:0]}, {5'd0, cap_data_o[31:5]});
    bits(3);
    cap_reg_i = 1'b1; bits(1);
    saved = cap_data_o;
    bits(7);
    cap_pin_i = 1'b1; bits(1); cap_pin_i = 1'b0;
    chk("R11 no load while other high", cap_data_o, saved);
    cap_reg_i = 1'b0; bits(2);

    // R10/R1: stuck streams
    prbs_sel_i = 1'b1; pat_len_i = 5'd6; tap_sel_i = 5'd5; src = 3;
    resync_pulse(); bits(50);
    chk("R10 all zeros flag", {31'd0, all_zeros_o}, 32'd1);
    chk("R1 zero stream accepted", {31'd0, sync_o}, 32'd1);
    src = 2; bits(40);
    chk("R10 all ones flag", {30'd0, all_ones_o, all_zeros_o}, 32'd2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule